// File: doc/BRIEF.md
# Command-Queue I2C Bus Master

This block is an I2C master engine driven by a queue of encoded command words rather than by a processor handshake on every byte. Software writes 11-bit commands into a command FIFO. The engine pops them one at a time and performs the matching bus action: a START followed by an address byte, transmission of a data byte, a burst of received bytes, or a STOP. Received bytes collect in a receive FIFO, which software drains through a data register. Each read of that register also reports whether the FIFO was empty.

Bit timing comes from an external timing generator as a single-cycle `bit_tick` strobe. Each tick moves the engine one quarter of an SCL period. The bus is open-drain: the engine only asserts pull-down enables, and the sampled line levels come back in on `scl_i` and `sda_i`.

Status flags report several conditions. The watermark-based data-request flags follow the FIFO levels. The sticky flags record stop done, unexpected NACK and arbitration loss. The busy flags show whether the engine holds the bus and whether the bus carries any traffic. Any enabled flag raises the interrupt line.

The engine has four states:
- `EN_IDLE` waits for a command. It takes **fetch** to `EN_START`, `EN_BIT` or `EN_STOP`, and **auto-stop** to `EN_STOP`.
- `EN_START` runs four quarter-steps: release SDA, release SCL, pull SDA low, pull SCL low. It then takes **start-done** to `EN_BIT`.
- `EN_BIT` shifts nine bits per byte: eight data bits and one acknowledge bit. It loops for each further byte of a burst. It leaves through **byte-done** or **arb-lost** to `EN_IDLE`.
- `EN_STOP` pulls SDA low, releases SCL, then releases SDA. It then takes **stop-done** to `EN_IDLE`.

Top module: `i2c_cmdq_master`

## Requirements
- R1: A command word carries its opcode in bits 10:8 and an 8-bit argument in bits 7:0. Opcode 4 issues START and then sends the argument as the address byte. Opcode 0 sends the argument as a data byte. Bytes go out MSB first, and the acknowledge bit is sampled on the ninth clock.
- R2: Opcode 1 receives argument+1 bytes (1 to 256) into the receive FIFO. The engine drives ACK after every byte except the last, and NACK after the last. A read of the data register (address 7) returns the oldest byte in bits 7:0 and pops it. Bit 14 of that read is 1 when the FIFO is empty.
- R3: Opcode 3 clocks in argument+1 bytes the same way as opcode 1, but stores none of them.
- R4: Opcode 2 issues STOP when the engine owns the bus. It then sets the stop flag (status bit 9) and clears master busy (status bit 24).
- R5: An unexpected NACK after a sent byte sets the NACK flag (status bit 10). While that flag is set, the engine takes no further commands and keeps the bus.
- R6: Opcodes 5 and 7 issue START and expect a NACK on the address byte. A NACK there sets no flag, and an ACK there sets the NACK flag. Opcodes 6 and 7 behave on the bus like 4 and 5.
- R7: When configuration bit 0 (address 2) is set, received NACKs are ignored.
- R8: When configuration bit 1 is set, the engine issues STOP by itself once it owns the bus and the command FIFO is empty.
- R9: The engine detects arbitration loss when it releases SDA on an outgoing bit but samples SDA low. It then sets arbitration lost (status bit 11), releases both lines and empties the command FIFO.
- R10: The transmit-request flag (status bit 0) is set while the command FIFO count is at or below the transmit watermark. The receive-ready flag (status bit 1) is set while the receive FIFO count is above the receive watermark. Both watermarks live in address 5: the transmit watermark in the low bits and the receive watermark from bit 16.
- R11: Writing 1 to status bits 9, 10 or 11 (address 3) clears them. The interrupt enable register (address 4) uses the status bit positions. `irq` is the OR of all enabled status bits.
- R12: The parameter register (address 0) returns log2 of the command FIFO depth in bits 3:0 and log2 of the receive FIFO depth in bits 11:8.
- R13: Bus busy (status bit 25) sets on a START condition seen on the lines and clears on a STOP condition. Master busy stays set while the engine holds the bus between commands.
- R14: The control register (address 1) works as follows. Bit 0 enables command fetch. Writing 1 to bit 1 empties the command FIFO, and writing 1 to bit 2 empties the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Quarter-bit strobe from the timing generator |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive FIFO at address 7) |
| addr | input | 3 | Register index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The hardest state to reach from the ports is arbitration loss. It needs a second driver to hold SDA low at the exact quarter-step in which the engine releases a 1 bit. The bench therefore models the bus as a wired-AND of the engine, a behavioural target and an extra contender pull-down. The contender is armed by the START the target observes, so it collides on the first address bit. The NACK halt is the other awkward case: the remaining commands must stay queued, and the bench checks this through the transmit-request flag before it flushes the queue and queues a recovery STOP.

// File: rtl/i2c_cmdq_pkg.sv
package i2c_cmdq_pkg;

    typedef enum logic [2:0] {
        OP_SEND     = 3'd0,
        OP_RECV     = 3'd1,
        OP_STOP     = 3'd2,
        OP_SKIP     = 3'd3,
        OP_START    = 3'd4,
        OP_START_NK = 3'd5,
        OP_HSTART   = 3'd6,
        OP_HSTART_NK= 3'd7
    } opcode_t;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_START,
        EN_BIT,
        EN_STOP
    } eng_state_t;

    localparam logic [2:0] RA_PARAM  = 3'd0;
    localparam logic [2:0] RA_CTRL   = 3'd1;
    localparam logic [2:0] RA_CFG    = 3'd2;
    localparam logic [2:0] RA_STATUS = 3'd3;
    localparam logic [2:0] RA_IEN    = 3'd4;
    localparam logic [2:0] RA_WMARK  = 3'd5;
    localparam logic [2:0] RA_CMD    = 3'd6;
    localparam logic [2:0] RA_RXDATA = 3'd7;

    localparam int SB_TXREQ = 0;
    localparam int SB_RXRDY = 1;
    localparam int SB_STOP  = 9;
    localparam int SB_NACK  = 10;
    localparam int SB_ARB   = 11;
    localparam int SB_MBUSY = 24;
    localparam int SB_BBUSY = 25;
    localparam int RX_EMPTY_BIT = 14;
    localparam int RXWM_LSB = 16;

endpackage

// File: rtl/i2c_cmdq_fifo.sv
module i2c_cmdq_fifo #(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [AW:0]   count,
    output logic          full,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rp];
    assign full  = (count == (AW+1)'(DEPTH));
    assign empty = (count == '0);

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> !full); // R2
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> !empty); // R1

endmodule

// File: rtl/i2c_cmdq_busmon.sv
module i2c_cmdq_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic bus_busy
);
    logic scl_q, sda_q;
    logic start_seen, stop_seen;

    assign start_seen = scl_q && scl_i && sda_q && !sda_i;
    assign stop_seen  = scl_q && scl_i && !sda_q && sda_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            bus_busy <= 1'b0;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
            if (start_seen)     bus_busy <= 1'b1;
            else if (stop_seen) bus_busy <= 1'b0;
        end
    end

    AST_BUS_FREE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !bus_busy); // R13

endmodule

// File: rtl/i2c_cmdq_engine.sv
module i2c_cmdq_engine
    import i2c_cmdq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        enable,
    input  logic        cfg_ignack,
    input  logic        cfg_autostop,
    input  logic        ndf_hold,
    input  logic        cmd_valid,
    input  logic [10:0] cmd_word,
    input  logic        rx_full,
    input  logic        sda_i,
    output logic        cmd_pop,
    output logic        cmd_flush,
    output logic        rx_push,
    output logic [7:0]  rx_byte,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        busy,
    output logic        ev_stop,
    output logic        ev_nack,
    output logic        ev_arb
);
    eng_state_t state;
    logic [1:0] ph;
    logic [3:0] bitn;
    logic [7:0] shreg;
    logic [7:0] rx_left;
    logic       is_rx, discard, is_addr, expect_nack, ack_bad, owned;
    logic       fetch, auto_stop, rx_wait, byte_end;
    opcode_t    op;

    assign op        = opcode_t'(cmd_word[10:8]);
    assign fetch     = (state == EN_IDLE) && tick && enable && !ndf_hold && cmd_valid;
    assign auto_stop = (state == EN_IDLE) && tick && enable && !ndf_hold && !cmd_valid
                       && owned && cfg_autostop;
    assign rx_wait   = is_rx && !discard && rx_full && (bitn == 4'd0);
    assign byte_end  = (state == EN_BIT) && tick && (ph == 2'd3) && (bitn == 4'd8);
    assign cmd_pop   = fetch;
    assign rx_push   = byte_end && is_rx && !discard;
    assign rx_byte   = shreg;
    assign busy      = owned || (state != EN_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= EN_IDLE;
            ph          <= '0;
            bitn        <= '0;
            shreg       <= '0;
            rx_left     <= '0;
            is_rx       <= 1'b0;
            discard     <= 1'b0;
            is_addr     <= 1'b0;
            expect_nack <= 1'b0;
            ack_bad     <= 1'b0;
            owned       <= 1'b0;
            scl_oe      <= 1'b0;
            sda_oe      <= 1'b0;
            ev_stop     <= 1'b0;
            ev_nack     <= 1'b0;
            ev_arb      <= 1'b0;
            cmd_flush   <= 1'b0;
        end else begin
            ev_stop   <= 1'b0;
            ev_nack   <= 1'b0;
            ev_arb    <= 1'b0;
            cmd_flush <= 1'b0;
            unique case (state)
                EN_IDLE: begin
                    ph   <= '0;
                    bitn <= '0;
                    if (fetch) begin
                        unique case (op)
                            OP_SEND: begin
                                shreg   <= cmd_word[7:0];
                                is_rx   <= 1'b0;
                                is_addr <= 1'b0;
                                state   <= EN_BIT;
                            end
                            OP_RECV, OP_SKIP: begin
                                rx_left <= cmd_word[7:0];
                                is_rx   <= 1'b1;
                                discard <= (op == OP_SKIP);
                                is_addr <= 1'b0;
                                state   <= EN_BIT;
                            end
                            OP_STOP: begin
                                if (owned) state <= EN_STOP;
                            end
                            default: begin
                                shreg       <= cmd_word[7:0];
                                is_rx       <= 1'b0;
                                is_addr     <= 1'b1;
                                expect_nack <= op[0];
                                state       <= EN_START;
                            end
                        endcase
                    end else if (auto_stop) begin
                        state <= EN_STOP;
                    end
                end
                EN_START: if (tick) begin
                    ph <= ph + 1'b1;
                    unique case (ph)
                        2'd0: sda_oe <= 1'b0;
                        2'd1: scl_oe <= 1'b0;
                        2'd2: sda_oe <= 1'b1;
                        default: begin
                            scl_oe <= 1'b1;
                            owned  <= 1'b1;
                            bitn   <= '0;
                            state  <= EN_BIT;
                        end
                    endcase
                end
                EN_BIT: if (tick) begin
                    unique case (ph)
                        2'd0: if (!rx_wait) begin
                            if (bitn != 4'd8) sda_oe <= is_rx ? 1'b0 : ~shreg[7];
                            else              sda_oe <= is_rx && (rx_left != 8'd0);
                            ph <= 2'd1;
                        end
                        2'd1: begin
                            scl_oe <= 1'b0;
                            ph     <= 2'd2;
                        end
                        2'd2: begin
                            ph <= 2'd3;
                            if (bitn != 4'd8) begin
                                if (is_rx) begin
                                    shreg <= {shreg[6:0], sda_i};
                                end else if (!sda_oe && !sda_i) begin
                                    ev_arb    <= 1'b1;
                                    cmd_flush <= 1'b1;
                                    scl_oe    <= 1'b0;
                                    sda_oe    <= 1'b0;
                                    owned     <= 1'b0;
                                    state     <= EN_IDLE;
                                end
                            end else begin
                                ack_bad <= !is_rx && !cfg_ignack &&
                                           ((is_addr && expect_nack) ? !sda_i : sda_i);
                            end
                        end
                        default: begin
                            scl_oe <= 1'b1;
                            ph     <= 2'd0;
                            if (bitn != 4'd8) begin
                                bitn <= bitn + 1'b1;
                                if (!is_rx) shreg <= {shreg[6:0], 1'b0};
                            end else begin
                                bitn <= '0;
                                if (is_rx) begin
                                    if (rx_left == 8'd0) state <= EN_IDLE;
                                    else                 rx_left <= rx_left - 1'b1;
                                end else begin
                                    state   <= EN_IDLE;
                                    ev_nack <= ack_bad;
                                end
                            end
                        end
                    endcase
                end
                EN_STOP: if (tick) begin
                    ph <= ph + 1'b1;
                    unique case (ph)
                        2'd0: sda_oe <= 1'b1;
                        2'd1: scl_oe <= 1'b0;
                        default: begin
                            sda_oe  <= 1'b0;
                            owned   <= 1'b0;
                            ev_stop <= 1'b1;
                            state   <= EN_IDLE;
                        end
                    endcase
                end
                default: state <= EN_IDLE;
            endcase
        end
    end

    AST_HALT_ON_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        ndf_hold |-> !cmd_pop); // R5
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EN_IDLE && !owned) |-> (!scl_oe && !sda_oe)); // R4
    AST_ARB_DROPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb |-> (!busy && !scl_oe && !sda_oe)); // R9

endmodule

// File: rtl/i2c_cmdq_master.sv
module i2c_cmdq_master
    import i2c_cmdq_pkg::*;
#(
    parameter int TX_AW = 2,
    parameter int RX_AW = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_tick,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        irq
);
    localparam int CMD_W = 11;

    logic              enable, cfg_ignack, cfg_autostop;
    logic              f_stop, f_nack, f_arb;
    logic [31:0]       ien, status;
    logic [TX_AW:0]    tx_wm, tx_count;
    logic [RX_AW:0]    rx_wm, rx_count;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [CMD_W-1:0]  cmd_head;
    logic [7:0]        rx_head, rx_byte;
    logic              cmd_pop, cmd_flush, rx_push, rx_pop;
    logic              eng_busy, ev_stop, ev_nack, ev_arb, bus_busy;
    logic              wr_ctrl, wr_status, wr_cmd;

    assign wr_ctrl   = wr_en && (addr == RA_CTRL);
    assign wr_status = wr_en && (addr == RA_STATUS);
    assign wr_cmd    = wr_en && (addr == RA_CMD) && !tx_full;
    assign rx_pop    = rd_en && (addr == RA_RXDATA) && !rx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable       <= 1'b0;
            cfg_ignack   <= 1'b0;
            cfg_autostop <= 1'b0;
            ien          <= '0;
            tx_wm        <= '0;
            rx_wm        <= '0;
            f_stop       <= 1'b0;
            f_nack       <= 1'b0;
            f_arb        <= 1'b0;
        end else begin
            if (wr_ctrl) enable <= wdata[0];
            if (wr_en && addr == RA_CFG) begin
                cfg_ignack   <= wdata[0];
                cfg_autostop <= wdata[1];
            end
            if (wr_en && addr == RA_IEN) ien <= wdata;
            if (wr_en && addr == RA_WMARK) begin
                tx_wm <= wdata[TX_AW:0];
                rx_wm <= wdata[RXWM_LSB +: RX_AW+1];
            end
            f_stop <= ev_stop || (f_stop && !(wr_status && wdata[SB_STOP]));
            f_nack <= ev_nack || (f_nack && !(wr_status && wdata[SB_NACK]));
            f_arb  <= ev_arb  || (f_arb  && !(wr_status && wdata[SB_ARB]));
        end
    end

    always_comb begin
        status            = '0;
        status[SB_TXREQ]  = (tx_count <= tx_wm);
        status[SB_RXRDY]  = (rx_count > rx_wm);
        status[SB_STOP]   = f_stop;
        status[SB_NACK]   = f_nack;
        status[SB_ARB]    = f_arb;
        status[SB_MBUSY]  = eng_busy;
        status[SB_BBUSY]  = bus_busy;
    end

    assign irq = |(status & ien);

    always_comb begin
        rdata = '0;
        unique case (addr)
            RA_PARAM:  begin
                rdata[3:0]  = 4'(TX_AW);
                rdata[11:8] = 4'(RX_AW);
            end
            RA_CTRL:   rdata[0] = enable;
            RA_CFG:    rdata[1:0] = {cfg_autostop, cfg_ignack};
            RA_STATUS: rdata = status;
            RA_IEN:    rdata = ien;
            RA_WMARK:  begin
                rdata[TX_AW:0]              = tx_wm;
                rdata[RXWM_LSB +: RX_AW+1]  = rx_wm;
            end
            RA_RXDATA: begin
                rdata[RX_EMPTY_BIT] = rx_empty;
                rdata[7:0]          = rx_empty ? 8'h00 : rx_head;
            end
            default:   rdata = '0;
        endcase
    end

    i2c_cmdq_fifo #(.W(CMD_W), .AW(TX_AW)) u_cmd_fifo (
        .clk(clk), .rst_n(rst_n),
        .flush(cmd_flush || (wr_ctrl && wdata[1])),
        .push(wr_cmd), .din(wdata[CMD_W-1:0]),
        .pop(cmd_pop), .dout(cmd_head),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    i2c_cmdq_fifo #(.W(8), .AW(RX_AW)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .flush(wr_ctrl && wdata[2]),
        .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    i2c_cmdq_engine u_engine (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick),
        .enable(enable), .cfg_ignack(cfg_ignack), .cfg_autostop(cfg_autostop),
        .ndf_hold(f_nack), .cmd_valid(!tx_empty), .cmd_word(cmd_head),
        .rx_full(rx_full), .sda_i(sda_i),
        .cmd_pop(cmd_pop), .cmd_flush(cmd_flush),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(eng_busy),
        .ev_stop(ev_stop), .ev_nack(ev_nack), .ev_arb(ev_arb)
    );

    i2c_cmdq_busmon u_busmon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .bus_busy(bus_busy)
    );

    AST_STOP_FLAG_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_stop) |-> !eng_busy); // R4
    AST_ARB_FLAG_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_arb) |-> !eng_busy); // R9

endmodule

// File: tb/i2c_cmdq_master_bench.sv
module i2c_cmdq_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        scl_oe, sda_oe, irq;
    logic        scl_i, sda_i;

    // target and contender on the wired-AND bus
    logic        t_drv = 1'b0;
    logic        ack_en = 1'b1;
    logic        arb_mode = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    assign scl_i = ~scl_oe;
    assign sda_i = ~(sda_oe | t_drv);

    always #2 clk = ~clk;
    always @(negedge clk) bit_tick <= ~bit_tick;

    i2c_cmdq_master u_i2c_cmdq_master (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
    );

    // behavioural target
    logic       p_scl = 1'b1, p_sda = 1'b1;
    logic       active = 1'b0, first = 1'b0, rdmode = 1'b0, rd_done = 1'b0;
    int         bitn = 0, rk = 0, cn = 0;
    logic [7:0] sh = '0, txb = '0;
    logic [7:0] capt [4];
    logic [3:0] mack = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_sda && !sda_i && p_scl && scl_i) begin
                active = 1'b1; first = 1'b1; rdmode = 1'b0; rd_done = 1'b0;
                bitn = -1; rk = 0; cn = 0; mack = '0;
            end else if (!p_sda && sda_i && p_scl && scl_i) begin
                active = 1'b0;
            end else if (active && !p_scl && scl_i) begin
                if (bitn >= 0 && bitn < 8) sh = {sh[6:0], sda_i};
                if (bitn == 8 && rdmode && !first) begin
                    mack[rk] = !sda_i;
                    if (sda_i) rd_done = 1'b1;
                end
            end else if (active && p_scl && !scl_i) begin
                bitn = bitn + 1;
                if (bitn == 9) begin
                    bitn = 0;
                    if (!first && rdmode) rk = rk + 1;
                    first = 1'b0;
                end
                t_drv = 1'b0;
                if (bitn == 0) begin
                    if (rdmode && !first && !rd_done) begin
                        txb = 8'h5A + 8'(rk) * 8'h11;
                        t_drv = ~txb[7];
                    end
                end else if (bitn < 8) begin
                    if (rdmode && !first && !rd_done) t_drv = ~txb[7-bitn];
                end else if (first) begin
                    rdmode = sh[0];
                    t_drv  = ack_en;
                end else if (!rdmode) begin
                    capt[cn] = sh;
                    cn = cn + 1;
                    t_drv = 1'b1;
                end
            end
            if (arb_mode && active) t_drv = 1'b1;
            p_scl = scl_i;
            p_sda = sda_i;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] op, input logic [7:0] arg);
        reg_wr(3'd6, {21'b0, op, arg});
    endtask

    task automatic settle();
        repeat (700) @(negedge clk);
    endtask

    localparam logic [31:0] MASK = 32'h0300_0E03;

    // {target acks address, data byte}
    localparam logic [8:0] WR_VEC [6] = '{
        {1'b1, 8'h3C}, {1'b1, 8'hFF}, {1'b0, 8'h81},
        {1'b1, 8'h00}, {1'b0, 8'h7E}, {1'b1, 8'hA5}
    };

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, all requirements unfinished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // reset state
        reg_rd(3'd3, r); chk("R10 reset status", r, 32'h0000_0001);
        chk("R11 reset irq", {31'b0, irq}, 32'd0);
        reg_rd(3'd0, r); chk("R12 param", r, 32'h0000_0202);
        reg_rd(3'd7, r); chk("R2 empty rx read", r, 32'h0000_4000);

        reg_wr(3'd1, 32'h1);

        // write vectors
        foreach (WR_VEC[i]) begin
            reg_wr(3'd3, 32'hE00);
            ack_en = WR_VEC[i][8];
            cmd(3'd4, 8'hA0);
            cmd(3'd0, WR_VEC[i][7:0]);
            cmd(3'd2, 8'h00);
            settle();
            reg_rd(3'd3, r);
            if (WR_VEC[i][8]) begin
                chk("R1 R4 write status", r & MASK, 32'h0000_0201);
                chk("R1 byte at target", {24'b0, capt[0]}, {24'b0, WR_VEC[i][7:0]});
            end else begin
                // R5: halted with two commands still queued
                chk("R5 nack halt status", r & MASK, 32'h0300_0400);
                reg_wr(3'd1, 32'h3);
                cmd(3'd2, 8'h00);
                reg_wr(3'd3, 32'h400);
                settle();
                reg_rd(3'd3, r);
                chk("R14 R5 recovery status", r & MASK, 32'h0000_0201);
            end
        end
        ack_en = 1'b1;

        // R11 interrupt and write-one-to-clear
        reg_wr(3'd4, 32'h200);
        #1 chk("R11 irq on stop flag", {31'b0, irq}, 32'd1);
        reg_wr(3'd3, 32'h200);
        reg_rd(3'd3, r);
        chk("R11 stop flag cleared", r & 32'h200, 32'd0);
        chk("R11 irq dropped", {31'b0, irq}, 32'd0);
        reg_wr(3'd4, 32'h0);

        // R13 hold bus between commands
        cmd(3'd4, 8'hA0);
        cmd(3'd0, 8'h33);
        settle();
        reg_rd(3'd3, r); chk("R13 held bus busy", r & MASK, 32'h0300_0001);
        cmd(3'd2, 8'h00);
        settle();
        reg_rd(3'd3, r); chk("R13 R4 released", r & MASK, 32'h0000_0201);

        // R2 receive burst of three
        reg_wr(3'd3, 32'hE00);
        reg_wr(3'd4, 32'h2);
        cmd(3'd4, 8'hA1);
        cmd(3'd1, 8'd2);
        cmd(3'd2, 8'h00);
        settle();
        reg_rd(3'd3, r); chk("R2 R10 read status", r & MASK, 32'h0000_0203);
        chk("R11 irq on rx ready", {31'b0, irq}, 32'd1);
        chk("R2 ack pattern", {28'b0, mack}, 32'h3);
        reg_rd(3'd7, r); chk("R2 byte0", r, 32'h5A);
        reg_rd(3'd7, r); chk("R2 byte1", r, 32'h6B);
        reg_rd(3'd7, r); chk("R2 byte2", r, 32'h7C);
        reg_rd(3'd7, r); chk("R2 drained", r, 32'h4000);
        chk("R10 irq after drain", {31'b0, irq}, 32'd0);
        reg_wr(3'd4, 32'h0);

        // R3 discard burst
        reg_wr(3'd3, 32'hE00);
        cmd(3'd4, 8'hA1);
        cmd(3'd3, 8'd1);
        cmd(3'd2, 8'h00);
        settle();
        reg_rd(3'd7, r); chk("R3 nothing stored", r, 32'h4000);
        chk("R3 ack pattern", {28'b0, mack}, 32'h1);
        reg_rd(3'd3, r); chk("R3 stop done", r & MASK, 32'h0000_0201);

        // R6 start expecting NACK
        reg_wr(3'd3, 32'hE00);
        ack_en = 1'b0;
        cmd(3'd5, 8'hA0);
        cmd(3'd2, 8'h00);
        settle();
        reg_rd(3'd3, r); chk("R6 expected nack no flag", r & MASK, 32'h0000_0201);
        reg_wr(3'd3, 32'hE00);
        ack_en = 1'b1;
        cmd(3'd7, 8'hA0);
        settle();
        reg_rd(3'd3, r); chk("R6 ack sets nack flag", r & MASK, 32'h0300_0401);
        cmd(3'd2, 8'h00);
        reg_wr(3'd3, 32'h400);
        settle();

        // R7 ignore NACK
        reg_wr(3'd3, 32'hE00);
        reg_wr(3'd2, 32'h1);
        ack_en = 1'b0;
        cmd(3'd4, 8'hA0);
        cmd(3'd0, 8'h11);
        cmd(3'd2, 8'h00);
        settle();
        reg_rd(3'd3, r); chk("R7 nack ignored", r & MASK, 32'h0000_0201);
        chk("R7 byte sent", {24'b0, capt[0]}, 32'h11);
        ack_en = 1'b1;

        // R8 auto stop
        reg_wr(3'd3, 32'hE00);
        reg_wr(3'd2, 32'h2);
        cmd(3'd4, 8'hA0);
        cmd(3'd0, 8'h22);
        settle();
        reg_rd(3'd3, r); chk("R8 auto stop", r & MASK, 32'h0000_0201);
        chk("R8 byte sent", {24'b0, capt[0]}, 32'h22);
        reg_wr(3'd2, 32'h0);

        // R10 transmit watermark, fetch disabled
        reg_wr(3'd1, 32'h0);
        reg_wr(3'd5, 32'h1);
        cmd(3'd0, 8'h01);
        reg_rd(3'd3, r); chk("R10 one queued at wm1", r & 32'h1, 32'h1);
        cmd(3'd0, 8'h02);
        reg_rd(3'd3, r); chk("R10 two queued at wm1", r & 32'h1, 32'h0);
        reg_wr(3'd1, 32'h2);
        reg_rd(3'd3, r); chk("R14 cmd flush", r & 32'h1, 32'h1);
        reg_wr(3'd5, 32'h0);
        reg_wr(3'd1, 32'h1);

        // R10 receive watermark and R14 rx flush
        reg_wr(3'd5, 32'h0001_0000);
        cmd(3'd4, 8'hA1);
        cmd(3'd1, 8'd1);
        cmd(3'd2, 8'h00);
        settle();
        reg_rd(3'd3, r); chk("R10 two above wm1", r & 32'h2, 32'h2);
        reg_rd(3'd7, r); chk("R2 first of two", r, 32'h5A);
        reg_rd(3'd3, r); chk("R10 one not above wm1", r & 32'h2, 32'h0);
        reg_wr(3'd1, 32'h5);
        reg_rd(3'd7, r); chk("R14 rx flush", r, 32'h4000);
        reg_wr(3'd5, 32'h0);

        // R9 arbitration loss
        reg_wr(3'd3, 32'hE00);
        arb_mode = 1'b1;
        cmd(3'd4, 8'hA0);
        cmd(3'd0, 8'h44);
        cmd(3'd2, 8'h00);
        settle();
        reg_rd(3'd3, r); chk("R9 arb lost, queue empty", r & 32'h0100_0E03, 32'h0000_0801);
        chk("R9 lines released", {30'b0, scl_oe, sda_oe}, 32'd0);
        @(negedge clk);
        arb_mode = 1'b0; t_drv = 1'b0;
        repeat (4) @(negedge clk);
        reg_rd(3'd3, r); chk("R13 bus free after foreign stop", r & 32'h0200_0000, 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule